// File: doc/BRIEF.md
# Set/Clear Interrupt Mask and Event Status Controller

This block gathers single-cycle event pulses from up to five sources (two timer underflows, an alarm match, a serial byte completion and an external flag line) and turns them into one active-low interrupt request. Each event is caught in a sticky pending bit. The pending bits collect until software reads them.

Software reaches the block through a single register offset, and that offset means different things for reads and writes. A write changes the enable mask. Bit 7 of the write data chooses the operation: when it is 1, every 1 in the low bits enables the matching source; when it is 0, every 1 disables the matching source. In both cases a 0 leaves the matching mask bit as it is.

A read returns the pending bits together with a summary bit in bit 7. The summary bit is set when any pending event is also enabled. The read then empties the pending register. An event that arrives in the same cycle as the read is not lost: it stays pending for the next read. The interrupt output is driven low for as long as the summary condition holds.

Top module: `irqc_top`

## Requirements
- R1: After reset the mask and all pending bits are zero, irq_no is high, and a read returns 0x00.
- R2: A write at offset 0xD with bit 7 = 1 sets every mask bit whose data bit in positions 4:0 is 1. Mask bits whose data bit is 0 keep their value.
- R3: A write at offset 0xD with bit 7 = 0 clears every mask bit whose data bit in positions 4:0 is 1. Mask bits whose data bit is 0 keep their value.
- R4: evt_i[k] latches into read-data bit k, for k = 0 to 4, in this order: timer A, timer B, alarm, serial byte, flag line. Read-data bits 6:5 always read 0.
- R5: Pending bits are OR-ed with new events on every clock and stay set until a read at offset 0xD.
- R6: A read at offset 0xD returns the pending bits combinationally in the same cycle, and clears them at the clock edge that ends the read.
- R7: Read-data bit 7 is 1 exactly when some pending bit is set whose mask bit is also set.
- R8: irq_no is low exactly while at least one pending bit has its mask bit set.
- R9: An event that arrives in the same cycle as a status read is pending after that read.
- R10: When a set-write enables a source whose event is already pending, irq_no goes low in the cycle after the write.
- R11: Accesses with sel_i low, or to any offset other than 0xD, do not change the mask or the pending bits, and rdata_o reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| addr_i | input | 4 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; 0 unless a status read is in progress |
| evt_i | input | 5 | Event pulses, one per source |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its default parameters: five sources, 8-bit data, a 4-bit offset and the register at 0xD. With only five mask bits, random set-writes and clear-writes move the mask through all of its states within a few hundred cycles. A 4-bit offset lets half of the random accesses miss the register, so the bench also covers the case where an access must change nothing. Directed sequences cover a read and an event in the same cycle, enabling a source whose event is already pending, and writes that touch the unused bits 6:5.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    MASK_HOLD = 2'd0,
    MASK_SET  = 2'd1,
    MASK_CLR  = 2'd2
  } mask_op_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hD
) (
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              op_bit_i,
  output logic              rd_hit_o,
  output mask_op_e          mask_op_o
);
  logic hit;
  assign hit      = sel_i && (addr_i == REG_ADDR);
  assign rd_hit_o = hit && rd_i;

  always_comb begin
    mask_op_o = MASK_HOLD;
    if (hit && wr_i) mask_op_o = op_bit_i ? MASK_SET : MASK_CLR;
  end
endmodule

// File: rtl/irqc_mask.sv
module irqc_mask
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  mask_op_e           op_i,
  input  logic [NUM_SRC-1:0] bits_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_d;

  always_comb begin
    unique case (op_i)
      MASK_SET: mask_d = mask_o | bits_i;
      MASK_CLR: mask_d = mask_o & ~bits_i;
      default:  mask_d = mask_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= mask_d;
  end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    // new event wins over clear so nothing is dropped across a read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pend_o[k] <= 1'b0;
      else if (clr_i) pend_o[k] <= evt_i[k];
      else            pend_o[k] <= pend_o[k] | evt_i[k];
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 5,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hD
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               irq_no
);
  localparam int unsigned OP_BIT  = DATA_W - 1;
  localparam int unsigned PAD_W   = OP_BIT - NUM_SRC;

  logic               rd_hit;
  mask_op_e           mask_op;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pend_q;
  logic               summary;
  logic               unused_wbits;

  assign unused_wbits = ^wdata_i[OP_BIT-1:NUM_SRC];

  irqc_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(REG_ADDR)
  ) u_decode (
    .sel_i    (sel_i),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .op_bit_i (wdata_i[OP_BIT]),
    .rd_hit_o (rd_hit),
    .mask_op_o(mask_op)
  );

  irqc_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (mask_op),
    .bits_i(wdata_i[NUM_SRC-1:0]),
    .mask_o(mask_q)
  );

  irqc_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rd_hit),
    .evt_i (evt_i),
    .pend_o(pend_q)
  );

  assign summary = |(pend_q & mask_q);
  assign irq_no  = ~summary;
  assign rdata_o = rd_hit ? {summary, {PAD_W{1'b0}}, pend_q} : '0;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NUM_SRC  = 5,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hD
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sel_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_i,
  input logic               rd_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [NUM_SRC-1:0] pend_q,
  input logic               irq_no
);
  logic hit, rd_hit, clr_wr;
  assign hit    = sel_i && (addr_i == REG_ADDR);
  assign rd_hit = hit && rd_i;
  assign clr_wr = hit && wr_i && !wdata_i[DATA_W-1];

  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_irq_high: assert (irq_no);

  a_r11_idle_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |-> rdata_o == '0);

  a_r4_pad_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |-> (rdata_o[DATA_W-2:0] >> NUM_SRC) == '0);

  a_r8_summary_vs_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |-> rdata_o[DATA_W-1] == !irq_no);

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && evt_i == '0) |=> irq_no);

  a_r5_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !rd_hit && !clr_wr) |=> !irq_no);

  a_r10_enable_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wr_i && wdata_i[DATA_W-1] && !rd_i &&
     |(wdata_i[NUM_SRC-1:0] & pend_q)) |=> !irq_no);
endmodule

bind irqc_top irqc_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .REG_ADDR(REG_ADDR)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .addr_i (addr_i),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .evt_i  (evt_i),
  .pend_q (pend_q),
  .irq_no (irq_no)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [4:0] evt_i = '0;
  logic       irq_no;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [4:0] m_mask = '0;
  logic [4:0] m_pend = '0;

  always #10 clk_i = ~clk_i;

  irqc_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .evt_i(evt_i), .irq_no(irq_no)
  );

  function automatic logic exp_irq_n(logic [4:0] mk, logic [4:0] pd);
    return ~|(mk & pd);
  endfunction

  function automatic logic [7:0] exp_rdata(logic hit_rd, logic [4:0] mk, logic [4:0] pd);
    return hit_rd ? {|(mk & pd), 2'b00, pd} : 8'h00;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, check combinational outputs, update model at edge
  task automatic cyc(string tag, logic s, logic [3:0] a, logic w, logic r,
                     logic [7:0] d, logic [4:0] e);
    logic hit;
    @(negedge clk_i);
    sel_i = s; addr_i = a; wr_i = w; rd_i = r; wdata_i = d; evt_i = e;
    #1;
    hit = s && (a == 4'hD);
    check({tag, " rdata"}, rdata_o, exp_rdata(hit && r, m_mask, m_pend));
    check({tag, " irq_no"}, {7'd0, irq_no}, {7'd0, exp_irq_n(m_mask, m_pend)});
    @(posedge clk_i);
    if (hit && r) m_pend = e;
    else          m_pend = m_pend | e;
    if (hit && w) m_mask = d[7] ? (m_mask | d[4:0]) : (m_mask & ~d[4:0]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234_5678));
    // R1 reset state
    sel_i = 1'b1; addr_i = 4'hD; rd_i = 1'b1;
    #5;
    check("R1 reset rdata", rdata_o, 8'h00);
    check("R1 reset irq_no", {7'd0, irq_no}, 8'h01);
    #40 rst_ni = 1'b1;
    cyc("R1", 1, 4'hD, 0, 1, 8'h00, 5'h00);

    // R4 bit positions, R5 accumulate, R7 summary without mask
    for (int k = 0; k < 5; k++) cyc("R4", 0, 4'h0, 0, 0, 8'h00, 5'(1 << k));
    cyc("R5", 0, 4'h0, 0, 0, 8'h00, 5'h00);
    cyc("R4 R7 read all", 1, 4'hD, 0, 1, 8'h00, 5'h00);
    cyc("R6 cleared", 1, 4'hD, 0, 1, 8'h00, 5'h00);

    // R10 enable a pending source
    cyc("R10 evt", 0, 4'h0, 0, 0, 8'h00, 5'h04);
    cyc("R10 set", 1, 4'hD, 1, 0, 8'h84, 5'h00);
    cyc("R10 irq", 0, 4'h0, 0, 0, 8'h00, 5'h00);
    // R9 event during read
    cyc("R9 read+evt", 1, 4'hD, 0, 1, 8'h00, 5'h10);
    cyc("R9 kept", 1, 4'hD, 0, 1, 8'h00, 5'h00);
    // R2/R3 with zeros untouched, and pad bits 6:5 written
    cyc("R2 set", 1, 4'hD, 1, 0, 8'hE3, 5'h00);
    cyc("R3 clr", 1, 4'hD, 1, 0, 8'h61, 5'h00);
    for (int k = 0; k < 5; k++) cyc("R2 R3 probe", 0, 4'h0, 0, 0, 8'h00, 5'(1 << k));
    cyc("R8 summary", 1, 4'hD, 0, 1, 8'h00, 5'h00);
    // R11 misses
    cyc("R11 pend", 0, 4'h0, 0, 0, 8'h00, 5'h1F);
    cyc("R11 wrong addr", 1, 4'hC, 1, 1, 8'h1F, 5'h00);
    cyc("R11 no sel", 0, 4'hD, 1, 1, 8'h9F, 5'h00);
    cyc("R11 still", 1, 4'hD, 0, 1, 8'h00, 5'h00);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic s, w, r;
      logic [3:0] a;
      logic [4:0] e;
      s = ($urandom % 10) < 7;
      a = ($urandom % 2) ? 4'hD : 4'($urandom);
      w = ($urandom % 4) == 0;
      r = ($urandom % 5) == 0;
      e = (($urandom % 3) == 0) ? 5'($urandom) : 5'h00;
      cyc("R2 R3 R5 R6 R7 R8 R9 random", s, a, w, r, 8'($urandom), e);
    end
    finish_run();
  end
endmodule